// File: doc/BRIEF.md
# Serial Register Command Interpreter

This block is the slave end of a serial peripheral link that reaches a small register set around an up/down counter. The first byte of every transaction, framed by a low select, is an instruction. Its top two bits name an operation and the next three name a target. The later bytes carry data in or out, most significant bit first. The targets are two 8-bit mode registers, a counter-width data register, the live counter, a snapshot latch of the same width, and the 8-bit status register.

The counter and the status flags are built outside this block. The block reaches them through a value input, clear and load pulses, and a status input with its own clear pulse. When the host reads the live counter, the block first copies the counter into the snapshot latch and then shifts the latch out, so the counter keeps counting throughout. The counter width is a parameter of 1 to 4 bytes. SCK, select and MOSI must already be synchronous to `clk`, and each SCK phase must last at least three `clk` cycles.

Top module: `spicmd_decoder`

## Requirements
- R1: After reset, both mode registers, the data register and the snapshot latch are zero, MISO is low, and no clear or load pulse is active.
- R2: The instruction byte is decoded as operation = bits 7:6 (00 clear, 01 read, 10 write, 11 load) and target = bits 5:3 (001 mode 0, 010 mode 1, 011 data, 100 counter, 101 snapshot, 110 status). Bits 2:0 have no effect.
- R3: Clear zeroes mode 0 or mode 1. Clear of the counter gives one `cnt_clear` pulse, and clear of the status register gives one `status_clear` pulse. Clear of the data register or the snapshot latch changes nothing.
- R4: Read of mode 0, mode 1 or status returns one data byte. Read of the snapshot latch returns CNT_BYTES bytes, MSB first. Every data bit after the register's last bit reads as 0.
- R5: Read of the counter captures `cnt_value` into the snapshot latch when the instruction byte completes and returns that value. A later snapshot read returns the same value even if the counter has moved.
- R6: Write stores the first data byte into mode 0 or mode 1. For the data register, data byte k (k = 1 is the most significant) fills the register MSB first up to CNT_BYTES bytes. Further bytes, and writes to any other target, change nothing.
- R7: Load of the counter gives one `cnt_load` pulse while `cnt_load_val` holds the data register. Load of the snapshot latch captures `cnt_value`. Load of any other target does nothing.
- R8: Raising select aborts the transaction. A partly received byte is discarded, and the next transaction begins again with an instruction byte.
- R9: MOSI is sampled on the rising SCK edge and MISO changes only after a falling edge. MISO is 0 during the instruction byte and while select is high.
- R10: Clear and load are single-byte commands. Any bytes that follow them in the same transaction are not treated as instructions and cause no action.
- R11: Target codes 000 and 111, and a read of the data register, cause no action and return zeros on MISO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low, synchronous to clk |
| spi_ss_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| cnt_value | input | 8*CNT_BYTES | Live counter value |
| status_in | input | 8 | Status flags from the counter logic |
| cnt_clear | output | 1 | One-cycle counter clear request |
| cnt_load | output | 1 | One-cycle counter load request |
| cnt_load_val | output | 8*CNT_BYTES | Data register contents; the value a load puts into the counter |
| status_clear | output | 1 | One-cycle status clear request |
| mode0 | output | 8 | Mode register 0 |
| mode1 | output | 8 | Mode register 1 |

## Verification
The bench reads the snapshot after it has changed the counter input. A design that shifts out the live counter instead of the captured copy returns the new value. Reads that run past the register width are checked for zero fill, which catches a shift register that wraps around or was not cleared. A clear or load byte followed by a byte that would itself be a valid instruction shows whether the byte counter wrongly treats a later byte as a new command. Transactions cut off in the middle of a byte, and bytes whose bits 2:0 are not zero, check for stray writes and for low instruction bits that leak into the decode.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

   typedef enum logic [1:0] {
      OP_CLR = 2'b00,
      OP_RD  = 2'b01,
      OP_WR  = 2'b10,
      OP_LD  = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      SEL_NONE_LO = 3'b000,
      SEL_MODE0   = 3'b001,
      SEL_MODE1   = 3'b010,
      SEL_DATA    = 3'b011,
      SEL_CNT     = 3'b100,
      SEL_SNAP    = 3'b101,
      SEL_STAT    = 3'b110,
      SEL_NONE_HI = 3'b111
   } sel_e;

   typedef struct packed {
      op_e  op;
      sel_e sel;
   } cmd_t;

   // bits 2:0 of the instruction are deliberately dropped
   function automatic cmd_t decode_cmd(input logic [7:0] b);
      cmd_t c;
      c.op  = op_e'(b[7:6]);
      c.sel = sel_e'(b[5:3]);
      return c;
   endfunction

endpackage

// File: rtl/spicmd_rx.sv
module spicmd_rx #(
   parameter int IDXW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_sck,
   input  logic            spi_ss_n,
   input  logic            spi_mosi,
   output logic            sck_fall,
   output logic            byte_valid,
   output logic [7:0]      byte_data,
   output logic [IDXW-1:0] byte_idx
);

   logic            sck_q;
   logic            sck_rise;
   logic [2:0]      bit_cnt;
   logic [6:0]      shift_q;
   logic [IDXW-1:0] idx_next;

   assign sck_rise = !spi_ss_n &&  spi_sck && !sck_q;
   assign sck_fall = !spi_ss_n && !spi_sck &&  sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         bit_cnt    <= '0;
         shift_q    <= '0;
         idx_next   <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
         byte_idx   <= '0;
      end else begin
         sck_q      <= spi_sck;
         byte_valid <= 1'b0;
         if (spi_ss_n) begin
            bit_cnt  <= '0;
            idx_next <= '0;
         end else if (sck_rise) begin
            shift_q <= {shift_q[5:0], spi_mosi};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_valid <= 1'b1;
               byte_data  <= {shift_q, spi_mosi};
               byte_idx   <= idx_next;
               if (idx_next != '1) idx_next <= idx_next + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spicmd_tx.sv
module spicmd_tx #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spi_ss_n,
   input  logic         sck_fall,
   input  logic         load,
   input  logic [W-1:0] word,
   output logic         spi_miso
);

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         spi_miso <= 1'b0;
      end else if (spi_ss_n) begin
         sr_q     <= '0;
         spi_miso <= 1'b0;
      end else if (load) begin
         sr_q <= word;
      end else if (sck_fall) begin
         spi_miso <= sr_q[W-1];
         sr_q     <= {sr_q[W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs
   import spicmd_pkg::*;
#(
   parameter int CNT_BYTES = 4,
   parameter int IDXW      = 3,
   localparam int W        = 8 * CNT_BYTES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_ss_n,
   input  logic            byte_valid,
   input  logic [7:0]      byte_data,
   input  logic [IDXW-1:0] byte_idx,
   input  logic [W-1:0]    cnt_value,
   input  logic [7:0]      status_in,
   output logic            tx_load,
   output logic [W-1:0]    tx_word,
   output logic            cnt_clear,
   output logic            cnt_load,
   output logic            status_clear,
   output logic [7:0]      mode0,
   output logic [7:0]      mode1,
   output logic [W-1:0]    data_reg
);

   cmd_t         cmd;
   logic         first_byte;
   logic         wr_act_q;
   sel_e         wr_sel_q;
   logic [W-1:0] snap_q;
   logic [W-1:0] mode0_al, mode1_al, stat_al;
   logic [7:0]   lane_q [CNT_BYTES];

   assign cmd        = decode_cmd(byte_data);
   assign first_byte = byte_valid && !spi_ss_n && (byte_idx == '0);

   // 8-bit registers are left-aligned in the shift word
   if (W > 8) begin : g_wide
      assign mode0_al = {mode0,     {(W-8){1'b0}}};
      assign mode1_al = {mode1,     {(W-8){1'b0}}};
      assign stat_al  = {status_in, {(W-8){1'b0}}};
   end else begin : g_narrow
      assign mode0_al = mode0;
      assign mode1_al = mode1;
      assign stat_al  = status_in;
   end

   always_comb begin
      tx_load = first_byte && (cmd.op == OP_RD);
      unique case (cmd.sel)
         SEL_MODE0: tx_word = mode0_al;
         SEL_MODE1: tx_word = mode1_al;
         SEL_CNT:   tx_word = cnt_value;
         SEL_SNAP:  tx_word = snap_q;
         SEL_STAT:  tx_word = stat_al;
         default:   tx_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q     <= 1'b0;
         wr_sel_q     <= SEL_NONE_LO;
         snap_q       <= '0;
         mode0        <= '0;
         mode1        <= '0;
         cnt_clear    <= 1'b0;
         cnt_load     <= 1'b0;
         status_clear <= 1'b0;
      end else begin
         cnt_clear    <= 1'b0;
         cnt_load     <= 1'b0;
         status_clear <= 1'b0;
         if (spi_ss_n) begin
            wr_act_q <= 1'b0;
         end else if (first_byte) begin
            wr_act_q <= (cmd.op == OP_WR);
            wr_sel_q <= cmd.sel;
            unique case (cmd.op)
               OP_CLR: begin
                  unique case (cmd.sel)
                     SEL_MODE0: mode0        <= '0;
                     SEL_MODE1: mode1        <= '0;
                     SEL_CNT:   cnt_clear    <= 1'b1;
                     SEL_STAT:  status_clear <= 1'b1;
                     default: ;
                  endcase
               end
               OP_RD: begin
                  if (cmd.sel == SEL_CNT) snap_q <= cnt_value;
               end
               OP_LD: begin
                  if (cmd.sel == SEL_CNT)  cnt_load <= 1'b1;
                  if (cmd.sel == SEL_SNAP) snap_q   <= cnt_value;
               end
               default: ;
            endcase
         end else if (byte_valid && wr_act_q && (byte_idx == IDXW'(1))) begin
            if (wr_sel_q == SEL_MODE0) mode0 <= byte_data;
            if (wr_sel_q == SEL_MODE1) mode1 <= byte_data;
         end
      end
   end

   // data register: one lane per byte, most significant lane written first
   for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (!spi_ss_n && byte_valid && wr_act_q && (wr_sel_q == SEL_DATA)
                      && (byte_idx == IDXW'(CNT_BYTES - g))) begin
            lane_q[g] <= byte_data;
         end
      end
      assign data_reg[g*8 +: 8] = lane_q[g];
   end

endmodule

// File: rtl/spicmd_decoder.sv
module spicmd_decoder #(
   parameter int CNT_BYTES = 4,
   localparam int W        = 8 * CNT_BYTES,
   localparam int IDXW     = $clog2(CNT_BYTES + 2)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spi_sck,
   input  logic         spi_ss_n,
   input  logic         spi_mosi,
   output logic         spi_miso,
   input  logic [W-1:0] cnt_value,
   input  logic [7:0]   status_in,
   output logic         cnt_clear,
   output logic         cnt_load,
   output logic [W-1:0] cnt_load_val,
   output logic         status_clear,
   output logic [7:0]   mode0,
   output logic [7:0]   mode1
);

   if (CNT_BYTES < 1 || CNT_BYTES > 4) begin : g_bad_width
      $error("spicmd_decoder: CNT_BYTES must be 1 to 4");
   end

   logic            sck_fall;
   logic            byte_valid;
   logic [7:0]      byte_data;
   logic [IDXW-1:0] byte_idx;
   logic            tx_load;
   logic [W-1:0]    tx_word;

   spicmd_rx #(.IDXW(IDXW)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sck    (spi_sck),
      .spi_ss_n   (spi_ss_n),
      .spi_mosi   (spi_mosi),
      .sck_fall   (sck_fall),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_idx   (byte_idx)
   );

   spicmd_regs #(.CNT_BYTES(CNT_BYTES), .IDXW(IDXW)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .spi_ss_n     (spi_ss_n),
      .byte_valid   (byte_valid),
      .byte_data    (byte_data),
      .byte_idx     (byte_idx),
      .cnt_value    (cnt_value),
      .status_in    (status_in),
      .tx_load      (tx_load),
      .tx_word      (tx_word),
      .cnt_clear    (cnt_clear),
      .cnt_load     (cnt_load),
      .status_clear (status_clear),
      .mode0        (mode0),
      .mode1        (mode1),
      .data_reg     (cnt_load_val)
   );

   spicmd_tx #(.W(W)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_ss_n (spi_ss_n),
      .sck_fall (sck_fall),
      .load     (tx_load),
      .word     (tx_word),
      .spi_miso (spi_miso)
   );

endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_sck,
   input logic       spi_ss_n,
   input logic       spi_miso,
   input logic       cnt_clear,
   input logic       cnt_load,
   input logic       status_clear,
   input logic [7:0] mode0,
   input logic [7:0] mode1
);

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cnt_clear, cnt_load, status_clear})); // R3

   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear |=> !cnt_clear); // R3

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> !cnt_load); // R7

   AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_ss_n |=> !spi_miso); // R9

   AST_MISO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_ss_n && $past(!spi_ss_n) && spi_sck && $past(spi_sck)) |-> $stable(spi_miso)); // R9

   AST_MODES_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_ss_n && $past(spi_ss_n) && $past(spi_ss_n, 2)) |-> ($stable(mode0) && $stable(mode1))); // R8

endmodule

bind spicmd_decoder spicmd_checker i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .spi_sck      (spi_sck),
   .spi_ss_n     (spi_ss_n),
   .spi_miso     (spi_miso),
   .cnt_clear    (cnt_clear),
   .cnt_load     (cnt_load),
   .status_clear (status_clear),
   .mode0        (mode0),
   .mode1        (mode1)
);

// File: tb/test_spicmd_decoder.sv
module test_spicmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_ss_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic [31:0] cnt_value = '0;
   logic [7:0]  status_in = '0;
   logic        cnt_clear, cnt_load, status_clear;
   logic [31:0] cnt_load_val;
   logic [7:0]  mode0, mode1;

   int nvec = 0;
   int nerr = 0;
   int n_load = 0, n_clr = 0, n_sclr = 0;
   logic [31:0] load_seen = '0;
   bit done = 1'b0;

   logic [7:0] txb [8];
   logic [7:0] rxb [8];
   logic [7:0] exp_q [$];
   logic [7:0] got_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   spicmd_decoder i_spicmd_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .spi_sck      (spi_sck),
      .spi_ss_n     (spi_ss_n),
      .spi_mosi     (spi_mosi),
      .spi_miso     (spi_miso),
      .cnt_value    (cnt_value),
      .status_in    (status_in),
      .cnt_clear    (cnt_clear),
      .cnt_load     (cnt_load),
      .cnt_load_val (cnt_load_val),
      .status_clear (status_clear),
      .mode0        (mode0),
      .mode1        (mode1)
   );

   always @(negedge clk) begin
      if (cnt_load) begin n_load++; load_seen = cnt_load_val; end
      if (cnt_clear) n_clr++;
      if (status_clear) n_sclr++;
   end

   // monitor: pop expected and received read bytes and compare
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0 && got_q.size() > 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            t = tag_q.pop_front();
            nvec++;
            if (g !== e) begin
               nerr++;
               $display("FAIL %s: MISO byte got %02h expected %02h", t, g, e);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input int nbytes, input int extra_bits);
      spi_ss_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int b = 0; b < nbytes + ((extra_bits > 0) ? 1 : 0); b++) begin
         int nbits;
         nbits = (b < nbytes) ? 8 : extra_bits;
         rxb[b] = '0;
         for (int i = 0; i < nbits; i++) begin
            spi_mosi = txb[b][7-i];
            repeat (3) @(negedge clk);
            rxb[b][7-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (4) @(negedge clk);
            spi_sck = 1'b0;
            @(negedge clk);
         end
      end
      repeat (3) @(negedge clk);
      spi_ss_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic cmd1(input logic [7:0] ins);
      txb[0] = ins;
      xfer(1, 0);
   endtask

   // read: expected word is left-aligned in 32 bits; bytes past it are zero
   task automatic rd(input logic [7:0] ins, input int ndata, input logic [31:0] word, input string tag);
      txb[0] = ins;
      for (int i = 1; i <= ndata; i++) txb[i] = 8'h00;
      for (int i = 0; i < ndata; i++) begin
         exp_q.push_back((i < 4) ? word[31-8*i -: 8] : 8'h00);
         tag_q.push_back(tag);
      end
      xfer(ndata + 1, 0);
      for (int i = 1; i <= ndata; i++) got_q.push_back(rxb[i]);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 mode0", mode0, 0);
      chk("R1 mode1", mode1, 0);
      chk("R1 data", cnt_load_val, 0);
      chk("R1 miso", spi_miso, 0);
      chk("R1 pulses", n_load + n_clr + n_sclr, 0);
      rd(8'h68, 4, 32'h0, "R1 snapshot");

      // writes; 0x8D has nonzero bits 2:0
      txb[0] = 8'h8D; txb[1] = 8'hA5; xfer(2, 0);
      chk("R2 R6 mode0 write", mode0, 8'hA5);
      txb[0] = 8'h90; txb[1] = 8'h3C; txb[2] = 8'hFF; xfer(3, 0);
      chk("R6 mode1 write, extra byte", mode1, 8'h3C);
      txb[0] = 8'h98; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h56; txb[4] = 8'h78; txb[5] = 8'hEE;
      xfer(6, 0);
      chk("R6 data write MSB first", cnt_load_val, 32'h12345678);

      // reads
      rd(8'h48, 2, 32'hA500_0000, "R4 mode0 read + zero fill");
      chk("R9 instruction-phase MISO", rxb[0], 0);
      status_in = 8'h5A;
      rd(8'h70, 1, 32'h5A00_0000, "R4 status read");
      cnt_value = 32'hDEADBEEF;
      rd(8'h60, 4, 32'hDEADBEEF, "R5 counter read");
      cnt_value = 32'h11111111;
      rd(8'h68, 5, 32'hDEADBEEF, "R5 R4 snapshot held");

      // loads
      cnt_value = 32'hCAFEF00D;
      cmd1(8'hE8);
      rd(8'h68, 4, 32'hCAFEF00D, "R7 snapshot load");
      cmd1(8'hE0);
      chk("R7 counter load pulse", n_load, 1);
      chk("R7 counter load value", load_seen, 32'h12345678);
      cmd1(8'hC8);
      chk("R7 load of mode0 ignored", mode0, 8'hA5);

      // clears
      cmd1(8'h20);
      chk("R3 counter clear pulse", n_clr, 1);
      cmd1(8'h30);
      chk("R3 status clear pulse", n_sclr, 1);
      cmd1(8'h28);
      rd(8'h68, 4, 32'hCAFEF00D, "R3 snapshot clear ignored");
      cmd1(8'h18);
      chk("R3 data clear ignored", cnt_load_val, 32'h12345678);
      cmd1(8'h08);
      chk("R3 mode0 cleared", mode0, 0);
      cmd1(8'h10);
      chk("R3 mode1 cleared", mode1, 0);
      txb[0] = 8'h8D; txb[1] = 8'hA5; xfer(2, 0);
      txb[0] = 8'h90; txb[1] = 8'h3C; xfer(2, 0);

      // writes to targets without write access
      txb[0] = 8'hA0; txb[1] = 8'h55; txb[2] = 8'h66; xfer(3, 0);
      chk("R6 counter write ignored", n_load, 1);
      chk("R6 data untouched", cnt_load_val, 32'h12345678);
      txb[0] = 8'hB0; txb[1] = 8'h01; xfer(2, 0);
      chk("R6 status write ignored", n_sclr, 1);
      txb[0] = 8'hB8; txb[1] = 8'hFF; xfer(2, 0);
      chk("R11 write none mode0", mode0, 8'hA5);
      chk("R11 write none mode1", mode1, 8'h3C);

      // single-byte commands followed by bytes that look like commands
      txb[0] = 8'hE0; txb[1] = 8'h20; xfer(2, 0);
      chk("R10 load then byte: load", n_load, 2);
      chk("R10 load then byte: no clear", n_clr, 1);
      txb[0] = 8'h20; txb[1] = 8'hE0; xfer(2, 0);
      chk("R10 clear then byte: clear", n_clr, 2);
      chk("R10 clear then byte: no load", n_load, 2);

      // unused selects and data register read
      rd(8'h40, 1, 32'h0, "R11 select 000");
      rd(8'h78, 1, 32'h0, "R11 select 111");
      rd(8'h58, 4, 32'h0, "R11 data read");

      // aborts
      txb[0] = 8'h90; txb[1] = 8'h00; xfer(1, 4);
      chk("R8 partial byte dropped", mode1, 8'h3C);
      txb[0] = 8'h08; xfer(0, 5);
      chk("R8 partial instruction dropped", mode0, 8'hA5);
      rd(8'h50, 1, 32'h3C00_0000, "R8 fresh transaction");
      chk("R9 MISO low when deselected", spi_miso, 0);

      repeat (4) @(negedge clk);
      chk("R4 scoreboard drained", exp_q.size() + got_q.size(), 0);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule